// File: doc/BRIEF.md
# Decimal-Capable 8-bit Accumulator ALU

A purely combinational arithmetic/logic unit for an 8-bit accumulator machine. Each cycle it takes a 4-bit operation code, the accumulator operand, the memory operand and the current processor status byte. It returns the 8-bit result and the new status byte. Instruction decode, registers and the memory bus stay outside. Whatever unit holds the accumulator registers the result and the status.

Addition and subtraction can run in binary or in packed BCD, as the decimal bit of the incoming status selects. In BCD, the binary sum is corrected once, using a term built from the nibble carries. That term is recovered by XOR-ing the biased sum with both operands. Sign and zero come from the binary sum before that correction. The remaining operations are the logic operations, a load, bit test, compare, shifts and rotates through carry. Each one changes only the flags it owns.

Top module: `bcd_alu`

## Requirements
- R1: Status byte bit positions are carry=0, zero=1, irq-mask=2, decimal=3, break=4, spare=5, overflow=6, sign=7; bits 2 to 5 of the output always equal those of the input.
- R2: Op 0 (add) with decimal=0: result is the low byte of A+M+carry, carry is bit 8 of that sum, overflow is bit 7 of (sum^A)&(sum^M), sign and zero come from the result.
- R3: Op 0 with decimal=1: after overflow is taken, the sum gains 3*((((sum+0x66)^A^M)>>3)&0x22); carry is set when that corrected sum exceeds 0xFF and the result is its low byte, while sign and zero still come from the low byte of the uncorrected sum.
- R4: Op 1 (subtract) replaces M by ~M, and in decimal mode further by (~M-0x66) mod 256, then follows R2/R3 with the incoming carry.
- R5: Ops 2, 3 and 4 (AND, OR, XOR with A) set sign and zero from the result and keep carry and overflow.
- R6: Op 11 (load) returns M, sets sign and zero from M and keeps carry and overflow.
- R7: Op 5 (bit test) returns A unchanged, sets zero when A&M is 0, copies M bit 7 to sign and M bit 6 to overflow, and keeps carry.
- R8: Op 6 (compare) returns A unchanged, sets carry when A>=M unsigned, takes sign and zero from the byte A-M, and keeps overflow.
- R9: Op 7 (shift left) moves A bit 7 into carry and fills bit 0 with 0; op 8 (logical shift right) moves A bit 0 into carry and clears bit 7; both set sign and zero from the result and keep overflow.
- R10: Op 9 (rotate left) puts the old carry into bit 0 and A bit 7 into carry; op 10 (rotate right) puts the old carry into bit 7 and A bit 0 into carry; overflow is kept.
- R11: Ops 12 to 15 return A and the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator operand |
| mem_in | input | 8 | Memory operand |
| status_in | input | 8 | Current status byte |
| result_out | output | 8 | Operation result |
| status_out | output | 8 | Updated status byte |

## Verification
The bench builds the block with its default of two BCD digits, an 8-bit datapath. That brings the decimal correction into reach at both nibble boundaries, including a carry out of the top digit that leaves a zero result while the zero flag stays clear. Directed vectors cover the decimal carry cases, signed overflow, the borrow of a decimal subtract and the unused codes. Several thousand random operand, status and code combinations are then compared against a behavioural model on every clock.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_BIT  = 4'd5,
    OP_CMP  = 4'd6,
    OP_SHL  = 4'd7,
    OP_SHR  = 4'd8,
    OP_ROL  = 4'd9,
    OP_ROR  = 4'd10,
    OP_LOAD = 4'd11
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic spare;
    logic brk;
    logic dec;
    logic irq;
    logic z;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/bcd_alu_addsub.sv
module bcd_alu_addsub #(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  input  logic         cin,
  input  logic         dec,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         n,
  output logic         z,
  output logic         v,
  output logic         c
);
  localparam logic [W+1:0] BIAS = {2'b00, {DIGITS{4'h6}}};
  localparam logic [W+1:0] MASK = {2'b00, {DIGITS{4'h2}}};

  logic [W-1:0] m_eff;
  logic [W+1:0] bin_sum, probe, hits, fix, fin;

  always_comb begin
    m_eff = sub ? ~m : m;
    if (sub && dec) m_eff = m_eff - BIAS[W-1:0];
    bin_sum = {2'b00, a} + {2'b00, m_eff} + {{(W+1){1'b0}}, cin};
    v = bin_sum[W-1] ^ a[W-1] && bin_sum[W-1] ^ m_eff[W-1];
    n = bin_sum[W-1];
    z = (bin_sum[W-1:0] == '0);
    probe = (bin_sum + BIAS) ^ {2'b00, a} ^ {2'b00, m_eff};
    hits = (probe >> 3) & MASK;
    fix = dec ? (hits + (hits << 1)) : '0;
    fin = bin_sum + fix;
    c = |fin[W+1:W];
    res = fin[W-1:0];
  end

  always_comb begin
    if (!dec && !sub && c) begin
      p_carry_wrap_r2: assert (res <= a)
        else $error("binary carry out without wraparound");
    end
    if (!dec && v) begin
      p_ovf_sign_r2: assert (a[W-1] == m_eff[W-1] && n != a[W-1])
        else $error("overflow flagged without sign change");
    end
  end
endmodule

// File: rtl/bcd_alu_logic.sv
module bcd_alu_logic
  import bcd_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  input  logic         cin,
  input  logic         vin,
  output logic [W-1:0] res,
  output logic         n,
  output logic         z,
  output logic         v,
  output logic         c
);
  logic [W:0] diff;

  always_comb begin
    diff = {1'b0, a} - {1'b0, m};
    res = a;
    c = cin;
    v = vin;
    unique case (op)
      OP_AND:  res = a & m;
      OP_OR:   res = a | m;
      OP_XOR:  res = a ^ m;
      OP_LOAD: res = m;
      default: res = a;
    endcase
    n = res[W-1];
    z = (res == '0);
    if (op == OP_CMP) begin
      n = diff[W-1];
      z = (diff[W-1:0] == '0);
      c = ~diff[W];
    end
    if (op == OP_BIT) begin
      n = m[W-1];
      v = m[W-2];
      z = ((a & m) == '0);
    end
  end

  always_comb begin
    if (op == OP_BIT || op == OP_CMP) begin
      p_keep_acc_r7: assert (res == a)
        else $error("test/compare altered the accumulator");
    end
    if (op == OP_CMP && m == '0) begin
      p_cmp_zero_r8: assert (c)
        else $error("compare against zero must set carry");
    end
  end
endmodule

// File: rtl/bcd_alu_shift.sv
module bcd_alu_shift
  import bcd_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         c
);
  logic fill;

  always_comb begin
    fill = (op == OP_ROL || op == OP_ROR) ? cin : 1'b0;
    if (op == OP_SHR || op == OP_ROR) begin
      res = {fill, a[W-1:1]};
      c = a[0];
    end else begin
      res = {a[W-2:0], fill};
      c = a[W-1];
    end
  end

  always_comb begin
    if (op == OP_SHR) begin
      p_lsr_msb_r9: assert (res[W-1] == 1'b0)
        else $error("logical right shift left a set top bit");
    end
    if (op == OP_ROR) begin
      p_ror_fill_r10: assert (res[W-1] == cin)
        else $error("rotate right did not feed carry into top bit");
    end
  end
endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
  import bcd_alu_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] mem_in,
  input  logic [7:0]   status_in,
  output logic [W-1:0] result_out,
  output logic [7:0]   status_out
);
  alu_op_e    op;
  alu_flags_t st_in, st_out;

  logic [W-1:0] as_res, lg_res, sh_res;
  logic as_n, as_z, as_v, as_c;
  logic lg_n, lg_z, lg_v, lg_c;
  logic sh_c;

  assign op    = alu_op_e'(op_sel);
  assign st_in = alu_flags_t'(status_in);

  bcd_alu_addsub #(.DIGITS(DIGITS)) u_addsub (
    .a(acc_in), .m(mem_in), .cin(st_in.c), .dec(st_in.dec),
    .sub(op == OP_SUB), .res(as_res), .n(as_n), .z(as_z), .v(as_v), .c(as_c)
  );

  bcd_alu_logic #(.W(W)) u_logic (
    .op(op), .a(acc_in), .m(mem_in), .cin(st_in.c), .vin(st_in.v),
    .res(lg_res), .n(lg_n), .z(lg_z), .v(lg_v), .c(lg_c)
  );

  bcd_alu_shift #(.W(W)) u_shift (
    .op(op), .a(acc_in), .cin(st_in.c), .res(sh_res), .c(sh_c)
  );

  always_comb begin
    st_out = st_in;
    result_out = acc_in;
    case (op)
      OP_ADD, OP_SUB: begin
        result_out = as_res;
        st_out.n = as_n; st_out.z = as_z; st_out.v = as_v; st_out.c = as_c;
      end
      OP_AND, OP_OR, OP_XOR, OP_BIT, OP_CMP, OP_LOAD: begin
        result_out = lg_res;
        st_out.n = lg_n; st_out.z = lg_z; st_out.v = lg_v; st_out.c = lg_c;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        result_out = sh_res;
        st_out.n = sh_res[W-1];
        st_out.z = (sh_res == '0);
        st_out.c = sh_c;
      end
      default: ;
    endcase
  end

  assign status_out = st_out;

  always_comb begin
    p_ctrl_keep_r1: assert (status_out[5:2] == status_in[5:2])
      else $error("control bits of status disturbed");
    if (op_sel >= 4'd12) begin
      p_idle_r11: assert (result_out == acc_in && status_out == status_in)
        else $error("unused code changed state");
    end
  end
endmodule

// File: tb/test_bcd_alu.sv
module test_bcd_alu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] op_sel = '0;
  logic [7:0] acc_in = '0, mem_in = '0, status_in = '0;
  logic [7:0] result_out, status_out;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  bcd_alu i_bcd_alu (
    .op_sel(op_sel), .acc_in(acc_in), .mem_in(mem_in), .status_in(status_in),
    .result_out(result_out), .status_out(status_out)
  );

  function automatic logic [15:0] model(input logic [3:0] op, input logic [7:0] a,
                                        input logic [7:0] m, input logic [7:0] s);
    int sum, mm, r;
    logic [7:0] st;
    st = s;
    r = a;
    case (op)
      4'd0, 4'd1: begin
        mm = (op == 4'd1) ? (~m & 255) : m;
        if (op == 4'd1 && s[3]) mm = (mm - 102) & 255;
        sum = a + mm + s[0];
        st[6] = (((sum ^ a) & (sum ^ mm) & 128) != 0);
        st[7] = ((sum & 128) != 0);
        st[1] = ((sum & 255) == 0);
        if (s[3]) sum = sum + (((((sum + 102) ^ a ^ mm) >> 3) & 34) * 3);
        st[0] = ((sum & 'hFF00) != 0);
        r = sum & 255;
      end
      4'd2, 4'd3, 4'd4, 4'd11: begin
        r = (op == 4'd2) ? (a & m) : (op == 4'd3) ? (a | m) :
            (op == 4'd4) ? (a ^ m) : m;
        st[7] = r[7]; st[1] = (r == 0);
      end
      4'd5: begin
        st[1] = ((a & m) == 0); st[7] = m[7]; st[6] = m[6];
      end
      4'd6: begin
        sum = (a - m) & 255;
        st[0] = (a >= m); st[7] = ((sum & 128) != 0); st[1] = (sum == 0);
      end
      4'd7, 4'd8, 4'd9, 4'd10: begin
        case (op)
          4'd7:    begin r = (a * 2) & 255;              st[0] = a[7]; end
          4'd8:    begin r = a / 2;                      st[0] = a[0]; end
          4'd9:    begin r = ((a * 2) & 255) + s[0];     st[0] = a[7]; end
          default: begin r = a / 2 + (s[0] ? 128 : 0);  st[0] = a[0]; end
        endcase
        st[7] = ((r & 128) != 0); st[1] = ((r & 255) == 0);
      end
      default: ;
    endcase
    return {r[7:0], st};
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0: return "R2/R3";
      4'd1: return "R4";
      4'd2, 4'd3, 4'd4: return "R5";
      4'd5: return "R7";
      4'd6: return "R8";
      4'd7, 4'd8: return "R9";
      4'd9, 4'd10: return "R10";
      4'd11: return "R6";
      default: return "R11";
    endcase
  endfunction

  task automatic run(input logic [3:0] op, input logic [7:0] a, input logic [7:0] m,
                     input logic [7:0] s, input string tag);
    logic [15:0] exp;
    @(posedge clk);
    op_sel = op; acc_in = a; mem_in = m; status_in = s;
    exp = model(op, a, m, s);
    @(negedge clk);
    n_run++;
    if (result_out !== exp[15:8] || status_out !== exp[7:0]) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%02h m=%02h s=%02h: got res=%02h st=%02h exp res=%02h st=%02h",
               tag, op, a, m, s, result_out, status_out, exp[15:8], exp[7:0]);
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got hang exp completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_run++;
    if (result_out !== 8'h00 || status_out !== 8'h02) begin
      n_fail++;
      $display("FAIL R2 reset idle: got res=%02h st=%02h exp res=00 st=02", result_out, status_out);
    end
    run(4'd0, 8'h7F, 8'h01, 8'h00, "R2 signed overflow");
    run(4'd0, 8'hFF, 8'h01, 8'h00, "R2 carry out");
    run(4'd0, 8'h09, 8'h01, 8'h08, "R3 low digit carry");
    run(4'd0, 8'h99, 8'h01, 8'h08, "R3 top digit carry, Z from binary");
    run(4'd0, 8'h45, 8'h38, 8'h09, "R3 decimal with carry in");
    run(4'd1, 8'h10, 8'h01, 8'h09, "R4 decimal borrow");
    run(4'd1, 8'h00, 8'h01, 8'h01, "R4 binary borrow");
    run(4'd5, 8'h0F, 8'hC0, 8'h01, "R7 bit test copy");
    run(4'd6, 8'h40, 8'h40, 8'h40, "R8 compare equal");
    run(4'd6, 8'h10, 8'h20, 8'h41, "R8 compare less");
    run(4'd8, 8'hFF, 8'h00, 8'h01, "R9 logical right");
    run(4'd10, 8'h01, 8'h00, 8'h01, "R10 rotate right");
    run(4'd9, 8'h80, 8'h00, 8'h00, "R10 rotate left to zero");
    run(4'd11, 8'h00, 8'h80, 8'h41, "R6 load");
    run(4'd13, 8'h5A, 8'hA5, 8'hFF, "R11 unused code");
    run(4'd3, 8'h00, 8'h00, 8'h3C, "R1 control bits kept");
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 15));
      run(op, 8'($urandom), 8'($urandom), 8'($urandom), req_of(op));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule